// File: doc/BRIEF.md
# Security-Banked Interrupt Group Control Register

This block holds the distributor-level control word of an interrupt controller: one enable for each interrupt group (group 0, non-secure group 1, secure group 1) and a flag that switches the two-world security model off. The same physical state is presented through three different read layouts. Which one is used depends on whether security is currently disabled and on whether the access is marked secure. Writes are masked according to the same two conditions.

With security on, a secure agent sees and controls everything. A non-secure agent sees only the non-secure group 1 enable, through an alias bit. Once a secure write sets the disable flag, the register collapses to a single two-enable layout for every agent, and the secure group 1 enable is cleared. The affinity-routing indicator bits always read as one. The current enables are driven to the interrupt selector, together with a per-group lookup output that the selector indexes by resolved group.

Top module: `secctl_top`

## Requirements
- R1: With the disable flag at 0, a secure read returns bit 0 = group 0 enable, bit 1 = non-secure group 1 enable, bit 2 = secure group 1 enable, bits 4 and 5 = 1, bit 6 = disable flag (0), and all other bits 0.
- R2: With the disable flag at 0, a non-secure read returns bit 4 = 1 and bit 1 = non-secure group 1 enable, and all other bits 0.
- R3: With the disable flag at 0, a non-secure write loads bit 1 into the non-secure group 1 enable and leaves the group 0 enable, the secure group 1 enable and the disable flag unchanged.
- R4: With the disable flag at 1, a read of either access type returns bit 6 = 1, bit 4 = 1, bit 1 = non-secure group 1 enable, bit 0 = group 0 enable, and all other bits 0.
- R5: With the disable flag at 1, a write of either access type loads bit 0 into the group 0 enable and bit 1 into the non-secure group 1 enable; the disable flag stays 1 and the secure group 1 enable stays 0.
- R6: With the disable flag at 0, a secure write loads bit 6 into the disable flag, bit 0 into the group 0 enable, bit 1 into the non-secure group 1 enable and bit 2 into the secure group 1 enable, except that the secure group 1 enable becomes 0 when bit 6 is written 1.
- R7: Bit 7, bit 3 and bits above 7 always read 0; writing 0 to bits 4 or 5 does not clear them in any later read.
- R8: After reset all three enables are 0 and the disable flag equals the inverse of the security-supported strap sampled during reset.
- R9: The group lookup output equals the group 0 enable for select code 0, the non-secure group 1 enable for code 1, the secure group 1 enable for code 2, and 0 for code 3.
- R10: The three enable outputs and the disable output show the register state, updated on the clock edge that takes a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_supported_i | input | 1 | Strap: two security states supported; sampled while reset is low |
| acc_secure_i | input | 1 | Current access is secure (selects read view and write mask) |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read view for the current access type |
| grp_sel_i | input | 2 | Resolved group code for the lookup |
| grp_enabled_o | output | 1 | Enable of the selected group |
| grp0_en_o | output | 1 | Group 0 enable |
| grp1ns_en_o | output | 1 | Non-secure group 1 enable |
| grp1s_en_o | output | 1 | Secure group 1 enable |
| sec_disabled_o | output | 1 | Security-disable flag |

## Verification
The assertions assume that reset is held low for at least one clock edge before any property is evaluated, that the strap is stable while reset is low, and that the access-type, write and select inputs are driven to known values whenever reset is high. The stimulus changes these inputs only on the falling clock edge, holds reset for two rising edges at each reset, and samples outputs mid-cycle against a behavioural model. Both strap settings are reset into, so the flag is seen starting at 0 and at 1, and random writes cover every mix of access type and data pattern including stray high bits.

// File: rtl/secctl_pkg.sv
package secctl_pkg;
   // Bit positions decoded by software; behaviour depends on them.
   localparam int BIT_G0    = 0;
   localparam int BIT_G1NS  = 1;
   localparam int BIT_G1S   = 2;
   localparam int BIT_RT_S  = 4;
   localparam int BIT_RT_NS = 5;
   localparam int BIT_DS    = 6;
   localparam int VIEW_W    = 8;
   localparam int GSEL_W    = 2;

   typedef enum logic [GSEL_W-1:0] {
      GRP_G0   = 2'd0,
      GRP_G1NS = 2'd1,
      GRP_G1S  = 2'd2,
      GRP_NONE = 2'd3
   } grp_e;

   typedef struct packed {
      logic ds;
      logic g1s;
      logic g1ns;
      logic g0;
   } ctl_state_t;
endpackage

// File: rtl/secctl_next.sv
module secctl_next
   import secctl_pkg::*;
(
   input  ctl_state_t         cur_i,
   input  logic               secure_i,
   input  logic [VIEW_W-1:0]  data_i,
   output ctl_state_t         nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      if (cur_i.ds) begin
         // collapsed layout: two enables only, flag is sticky
         nxt_o.g0   = data_i[BIT_G0];
         nxt_o.g1ns = data_i[BIT_G1NS];
      end else if (secure_i) begin
         nxt_o.ds   = data_i[BIT_DS];
         nxt_o.g0   = data_i[BIT_G0];
         nxt_o.g1ns = data_i[BIT_G1NS];
         nxt_o.g1s  = data_i[BIT_G1S] & ~data_i[BIT_DS];
      end else begin
         // non-secure agent reaches only the aliased enable
         nxt_o.g1ns = data_i[BIT_G1NS];
      end
   end
endmodule

// File: rtl/secctl_view.sv
module secctl_view
   import secctl_pkg::*;
(
   input  ctl_state_t         cur_i,
   input  logic               secure_i,
   output logic [VIEW_W-1:0]  view_o
);
   always_comb begin
      view_o = '0;
      view_o[BIT_RT_S] = 1'b1;
      if (cur_i.ds) begin
         view_o[BIT_DS]   = 1'b1;
         view_o[BIT_G1NS] = cur_i.g1ns;
         view_o[BIT_G0]   = cur_i.g0;
      end else if (secure_i) begin
         view_o[BIT_RT_NS] = 1'b1;
         view_o[BIT_DS]    = cur_i.ds;
         view_o[BIT_G1S]   = cur_i.g1s;
         view_o[BIT_G1NS]  = cur_i.g1ns;
         view_o[BIT_G0]    = cur_i.g0;
      end else begin
         view_o[BIT_G1NS] = cur_i.g1ns;
      end
   end
endmodule

// File: rtl/secctl_gsel.sv
module secctl_gsel
   import secctl_pkg::*;
(
   input  ctl_state_t         cur_i,
   input  logic [GSEL_W-1:0]  sel_i,
   output logic               en_o
);
   always_comb begin
      unique case (grp_e'(sel_i))
         GRP_G0:   en_o = cur_i.g0;
         GRP_G1NS: en_o = cur_i.g1ns;
         GRP_G1S:  en_o = cur_i.g1s;
         default:  en_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/secctl_top.sv
module secctl_top
   import secctl_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_supported_i,
   input  logic               acc_secure_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic [GSEL_W-1:0]  grp_sel_i,
   output logic               grp_enabled_o,
   output logic               grp0_en_o,
   output logic               grp1ns_en_o,
   output logic               grp1s_en_o,
   output logic               sec_disabled_o
);
   localparam int PAD_W = DATA_W - VIEW_W;

   generate
      if (DATA_W < VIEW_W) begin : g_bad_width
         $error("secctl_top: DATA_W must be at least %0d", VIEW_W);
      end
   endgenerate

   ctl_state_t        st_q, st_nxt;
   logic [VIEW_W-1:0] view;

   secctl_next u_next (
      .cur_i    (st_q),
      .secure_i (acc_secure_i),
      .data_i   (wr_data_i[VIEW_W-1:0]),
      .nxt_o    (st_nxt)
   );

   secctl_view u_view (
      .cur_i    (st_q),
      .secure_i (acc_secure_i),
      .view_o   (view)
   );

   secctl_gsel u_gsel (
      .cur_i (st_q),
      .sel_i (grp_sel_i),
      .en_o  (grp_enabled_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q.ds   <= ~sec_supported_i;
         st_q.g1s  <= 1'b0;
         st_q.g1ns <= 1'b0;
         st_q.g0   <= 1'b0;
      end else if (wr_en_i) begin
         st_q <= st_nxt;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data_o = {{PAD_W{1'b0}}, view};
      end else begin : g_nopad
         assign rd_data_o = view;
      end
   endgenerate

   assign grp0_en_o      = st_q.g0;
   assign grp1ns_en_o    = st_q.g1ns;
   assign grp1s_en_o     = st_q.g1s;
   assign sec_disabled_o = st_q.ds;
endmodule

// File: rtl/secctl_chk.sv
module secctl_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              acc_secure_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [1:0]        grp_sel_i,
   input logic              grp_enabled_o,
   input logic              grp0_en_o,
   input logic              grp1ns_en_o,
   input logic              grp1s_en_o,
   input logic              sec_disabled_o
);
   // R5: once disabled, the flag stays set until reset
   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sec_disabled_o) |-> sec_disabled_o);

   // R6: secure group 1 can never be enabled while security is off
   a_r6_ds_kills_g1s: assert property (@(posedge clk) disable iff (!rst_n)
      sec_disabled_o |-> !grp1s_en_o);

   // R3: non-secure write under security touches only the alias enable
   a_r3_ns_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !acc_secure_i && !sec_disabled_o) |=>
         ($stable(grp0_en_o) && $stable(grp1s_en_o) && $stable(sec_disabled_o)));

   // R7: routing bit reads one, bit 7 reads zero, in every view
   a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[4] && !rd_data_o[7] && !rd_data_o[3]);

   // R9: lookup follows the enable picked by the select code
   a_r9_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel_i == 2'd1) |-> (grp_enabled_o == grp1ns_en_o));

   // R10: no write, no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(grp0_en_o) && $stable(grp1ns_en_o)));
endmodule

bind secctl_top secctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .acc_secure_i   (acc_secure_i),
   .wr_en_i        (wr_en_i),
   .wr_data_i      (wr_data_i),
   .rd_data_o      (rd_data_o),
   .grp_sel_i      (grp_sel_i),
   .grp_enabled_o  (grp_enabled_o),
   .grp0_en_o      (grp0_en_o),
   .grp1ns_en_o    (grp1ns_en_o),
   .grp1s_en_o     (grp1s_en_o),
   .sec_disabled_o (sec_disabled_o)
);

// File: tb/tb_secctl_top.sv
`timescale 1ns/1ps
module tb_secctl_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap = 1'b1;
   logic          sec = 1'b0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdat = '0;
   logic [DW-1:0] rdat;
   logic [1:0]    gsel = 2'd0;
   logic          gen, g0o, g1nso, g1so, dso;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   bit m_ds, m_g0, m_g1ns, m_g1s;

   always #2 clk = ~clk;

   secctl_top #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .sec_supported_i(strap),
      .acc_secure_i(sec), .wr_en_i(wr), .wr_data_i(wdat),
      .rd_data_o(rdat), .grp_sel_i(gsel), .grp_enabled_o(gen),
      .grp0_en_o(g0o), .grp1ns_en_o(g1nso), .grp1s_en_o(g1so),
      .sec_disabled_o(dso)
   );

   function automatic logic [DW-1:0] exp_view(bit s);
      logic [DW-1:0] v = '0;
      v[4] = 1'b1;
      if (m_ds) begin
         v[6] = 1'b1; v[1] = m_g1ns; v[0] = m_g0;
      end else if (s) begin
         v[5] = 1'b1; v[2] = m_g1s; v[1] = m_g1ns; v[0] = m_g0;
      end else begin
         v[1] = m_g1ns;
      end
      return v;
   endfunction

   function automatic bit exp_lookup(logic [1:0] c);
      case (c)
         2'd0: return m_g0;
         2'd1: return m_g1ns;
         2'd2: return m_g1s;
         default: return 1'b0;
      endcase
   endfunction

   task automatic cmp(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, compare mid-cycle, advance model at rising edge
   task automatic step(string tag, bit s, bit w, logic [DW-1:0] d, logic [1:0] g);
      @(negedge clk);
      sec = s; wr = w; wdat = d; gsel = g;
      #1;
      cmp(tag, "rd_data", rdat, exp_view(s));
      cmp(tag, "lookup", gen, exp_lookup(g));
      cmp("R10", "enables", {dso, g1so, g1nso, g0o}, {m_ds, m_g1s, m_g1ns, m_g0});
      @(posedge clk);
      if (w) begin
         if (m_ds) begin
            m_g0 = d[0]; m_g1ns = d[1];
         end else if (s) begin
            m_ds = d[6]; m_g0 = d[0]; m_g1ns = d[1]; m_g1s = d[2] && !d[6];
         end else begin
            m_g1ns = d[1];
         end
      end
   endtask

   task automatic do_reset(bit sup);
      @(negedge clk);
      rst_n = 1'b0; strap = sup; wr = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_ds = !sup; m_g0 = 0; m_g1ns = 0; m_g1s = 0;
      #1;
      cmp("R8", "reset state", {dso, g1so, g1nso, g0o}, {!sup, 3'b000});
   endtask

   task automatic rand_run(int n);
      for (int i = 0; i < n; i++) begin
         step("R10", 1'($urandom), 1'($urandom), $urandom, 2'($urandom));
      end
   endtask

   initial begin
      do_reset(1'b1);
      step("R1", 1, 0, '0, 2'd0);
      step("R2", 0, 0, '0, 2'd2);
      // secure write with routing bits written 0
      step("R6", 1, 1, 32'h0000_0007, 2'd0);
      step("R1", 1, 0, '0, 2'd2);
      step("R7", 1, 0, '0, 2'd1);
      step("R2", 0, 0, '0, 2'd1);
      // non-secure writes reach only the alias
      step("R3", 0, 1, 32'hFFFF_FFFD, 2'd0);
      step("R3", 1, 0, '0, 2'd2);
      step("R3", 0, 1, 32'h0000_0002, 2'd1);
      for (int c = 0; c < 4; c++) step("R9", 1, 0, '0, 2'(c));
      // disable security: secure group 1 forced off
      step("R6", 1, 1, 32'h0000_0047, 2'd2);
      step("R4", 1, 0, '0, 2'd2);
      step("R4", 0, 0, '0, 2'd0);
      step("R5", 1, 1, 32'hFFFF_FFFC, 2'd0);
      step("R5", 0, 1, 32'h0000_0005, 2'd2);
      step("R5", 1, 1, 32'h0000_0002, 2'd1);
      step("R7", 0, 0, '0, 2'd3);
      rand_run(300);
      do_reset(1'b0);
      step("R4", 0, 0, '0, 2'd0);
      step("R5", 1, 1, 32'h0000_0007, 2'd2);
      step("R9", 0, 0, '0, 2'd2);
      rand_run(300);
      do_reset(1'b1);
      rand_run(600);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule